// File: doc/BRIEF.md
# Synchronous Serial Port with Shared Interrupt Request

This block is a byte-wide synchronous serial port seen by a processor through a small register window. An external shift-clock enable paces both directions. On every enabled cycle the receive shifter takes one bit from the serial input, and after eight bits the assembled byte is copied into a receive buffer. A byte that the processor writes to the data register is sent out most significant bit first, one bit per enabled cycle. There is no start or stop bit, no baud generator and no FIFO.

Two hardware flags report the port's state: receive-full, set when a character completes, and transmit-empty, set when the last bit of a character has left. The processor clears each flag by writing a one to its status bit. Each flag passes through its own enable bit, and the two results are ORed into one level-sensitive, active-high request. Both directions therefore share one interrupt entry, and the handler reads the status register to find the cause. Because the request is a level, two flags that rise in the same cycle keep the request high until the handler has cleared both. A character that completes while the previous one is still unread overwrites the buffer and raises a sticky overrun bit.

Top module: `serial_irq_port`

## Requirements
- R1: After reset the status register (address 1) reads 0x02 (transmit-empty set, receive-full and overrun clear), the enable register (address 2) reads 0, the data register (address 0) reads 0, `irqReq` is low and `serOut` is high.
- R2: On each cycle with `shiftEn` high, `serIn` is shifted in, and the first bit received ends up in bit 7. On the eighth such cycle the byte is copied to the receive buffer, and from the next cycle it reads at address 0 with status bit 0 (receive-full) set.
- R3: A write to address 0 loads the transmit shifter and clears status bit 1 (transmit-empty). `serOut` then shows bit 7, and each `shiftEn` cycle moves to the next lower bit. After the eighth `shiftEn` cycle `serOut` returns high and status bit 1 is set.
- R4: `irqReq` is high exactly when (status bit 0 AND enable bit 0) OR (status bit 1 AND enable bit 1). It is a level that stays high until a write clears the flag or the enable bit.
- R5: When receive completion and transmit completion fall in the same cycle, both flags are set. With both enable bits set, `irqReq` stays high after only one of the two flags is cleared, and drops only when both are cleared.
- R6: Writing address 1 clears each of status bits 0, 1 and 2 that is written as one, and leaves the bits written as zero unchanged.
- R7: When a hardware set of a flag and a processor clear of that flag fall in the same cycle, the flag ends up set.
- R8: If a character completes while receive-full is still set, the buffer takes the new byte and status bit 2 (overrun) is set. Bit 2 stays set until it is cleared through R6.
- R9: Address 2 holds two enable bits (bit 0 receive, bit 1 transmit) that read back as written. Cycles with `shiftEn` low move neither shifter, and reads have no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| shiftEn | input | 1 | Shift-clock enable, one bit per high cycle |
| serIn | input | 1 | Serial receive data |
| serOut | output | 1 | Serial transmit data, high when idle |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Write address: 0 data, 1 status, 2 enables |
| wrData | input | 8 | Write data |
| rdAddr | input | 2 | Read address, same map as wrAddr |
| rdData | output | 8 | Combinational read data |
| irqReq | output | 1 | Level-sensitive shared interrupt request |

## Verification
The bench drives frames in which receive and transmit complete on the same shift cycle and checks that the request outlives the clearing of one flag. A design that treated the request as an edge, or that merged the two sets, would drop the request with one cause still pending. The bench also clears receive-full in the very cycle the eighth bit arrives; a design that let the clear win would lose a character. It fills the buffer twice without a read to reach the overrun bit, and puts random idle cycles between shift pulses, which catches shifters that advance without the enable and transmitters that send the bits in the wrong order.

// File: rtl/serport_pkg.sv
package serport_pkg;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd2;

  localparam int BIT_RX  = 0;
  localparam int BIT_TX  = 1;
  localparam int BIT_OVR = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic txLoad;
    logic shift;
  } ctrlStrobe_t;

  // datapath -> control events
  typedef struct packed {
    logic rxDone;
    logic txDone;
  } dpEvent_t;
endpackage

// File: rtl/serport_dp.sv
module serport_dp
  import serport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] txByte,
  input  logic              serIn,
  output logic              serOut,
  output logic [DATA_W-1:0] rxBuf,
  output dpEvent_t          evt
);
  localparam int TXC_W = $clog2(DATA_W + 1);
  localparam int RXC_W = $clog2(DATA_W);
  localparam logic [TXC_W-1:0] TX_FULL = TXC_W'(DATA_W);
  localparam logic [TXC_W-1:0] TX_LAST = TXC_W'(1);
  localparam logic [RXC_W-1:0] RX_LAST = RXC_W'(DATA_W - 1);

  logic [DATA_W-1:0] txShift;
  logic [TXC_W-1:0]  txCnt;
  logic              txBusy;
  logic [DATA_W-2:0] rxShift;
  logic [RXC_W-1:0]  rxCnt;

  assign evt.txDone = strobe.shift && txBusy && (txCnt == TX_LAST) && !strobe.txLoad;
  assign evt.rxDone = strobe.shift && (rxCnt == RX_LAST);
  assign serOut     = txBusy ? txShift[DATA_W-1] : 1'b1;

  // transmit: parallel in, serial out, MSB first
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      txCnt   <= '0;
      txBusy  <= 1'b0;
    end else if (strobe.txLoad) begin
      txShift <= txByte;
      txCnt   <= TX_FULL;
      txBusy  <= 1'b1;
    end else if (strobe.shift && txBusy) begin
      txShift <= {txShift[DATA_W-2:0], 1'b0};
      txCnt   <= txCnt - TX_LAST;
      if (txCnt == TX_LAST) txBusy <= 1'b0;
    end
  end

  // receive: serial in, parallel out
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      rxCnt   <= '0;
      rxBuf   <= '0;
    end else if (strobe.shift) begin
      rxShift <= {rxShift[DATA_W-3:0], serIn};
      if (rxCnt == RX_LAST) begin
        rxCnt <= '0;
        rxBuf <= {rxShift, serIn};
      end else begin
        rxCnt <= rxCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serport_ctrl.sv
module serport_ctrl
  import serport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [2:0]        wrBits,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rxBuf,
  input  dpEvent_t          evt,
  output ctrlStrobe_t       strobe,
  output logic [DATA_W-1:0] rdData,
  output logic              rxFull,
  output logic              txEmpty,
  output logic              overrun,
  output logic [1:0]        maskBits,
  output logic              irqReq
);
  logic statWr;
  logic clrRx, clrTx, clrOvr;

  assign statWr        = wrEn && (wrAddr == ADDR_STAT);
  assign clrRx         = statWr && wrBits[BIT_RX];
  assign clrTx         = statWr && wrBits[BIT_TX];
  assign clrOvr        = statWr && wrBits[BIT_OVR];
  assign strobe.txLoad = wrEn && (wrAddr == ADDR_DATA);
  assign strobe.shift  = shiftEn;

  // flags: hardware set has priority over processor clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFull  <= 1'b0;
      txEmpty <= 1'b1;
      overrun <= 1'b0;
    end else begin
      if (evt.rxDone)   rxFull <= 1'b1;
      else if (clrRx)   rxFull <= 1'b0;

      if (evt.txDone)                   txEmpty <= 1'b1;
      else if (clrTx || strobe.txLoad)  txEmpty <= 1'b0;

      if (evt.rxDone && rxFull) overrun <= 1'b1;
      else if (clrOvr)          overrun <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              maskBits <= '0;
    else if (wrEn && (wrAddr == ADDR_MASK)) maskBits <= wrBits[1:0];
  end

  assign irqReq = (rxFull & maskBits[BIT_RX]) | (txEmpty & maskBits[BIT_TX]);

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_DATA: rdData = rxBuf;
      ADDR_STAT: begin
        rdData[BIT_RX]  = rxFull;
        rdData[BIT_TX]  = txEmpty;
        rdData[BIT_OVR] = overrun;
      end
      ADDR_MASK: rdData[1:0] = maskBits;
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/serial_irq_port.sv
module serial_irq_port
  import serport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftEn,
  input  logic              serIn,
  output logic              serOut,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [1:0]        rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              irqReq
);
  ctrlStrobe_t       strobe;
  dpEvent_t          dpEvt;
  logic [DATA_W-1:0] rxBuf;
  logic              rxFull, txEmpty, overrun;
  logic [1:0]        maskBits;

  serport_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrBits(wrData[2:0]),
    .rdAddr(rdAddr), .rxBuf(rxBuf), .evt(dpEvt),
    .strobe(strobe), .rdData(rdData),
    .rxFull(rxFull), .txEmpty(txEmpty), .overrun(overrun),
    .maskBits(maskBits), .irqReq(irqReq)
  );

  serport_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txByte(wrData),
    .serIn(serIn), .serOut(serOut), .rxBuf(rxBuf), .evt(dpEvt)
  );
endmodule

// File: rtl/serport_chk.sv
module serport_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic       rxDone,
  input logic       txDone,
  input logic       rxFull,
  input logic       txEmpty,
  input logic       overrun,
  input logic [1:0] maskBits,
  input logic       serOut,
  input logic       irqReq
);
  // R2
  rx_flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxDone |=> rxFull);
  // R3
  tx_idle_after_chk: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> (txEmpty && serOut));
  // R4
  irq_level_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqReq && !wrEn) |=> irqReq);
  // R5
  both_sources_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && txDone && maskBits == 2'b11) |=> (irqReq && rxFull && txEmpty));
  // R8
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone && rxFull) |=> overrun);
  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (overrun && !wrEn) |=> overrun);
endmodule

bind serial_irq_port serport_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn),
  .rxDone(dpEvt.rxDone), .txDone(dpEvt.txDone),
  .rxFull(rxFull), .txEmpty(txEmpty), .overrun(overrun),
  .maskBits(maskBits), .serOut(serOut), .irqReq(irqReq)
);

// File: tb/serial_irq_port_tb.sv
`timescale 1ns/1ps
module serial_irq_port_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       shiftEn = 1'b0, serIn = 1'b0, wrEn = 1'b0;
  logic [1:0] wrAddr = '0, rdAddr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       serOut, irqReq;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  // bench model
  bit       mRx = 0, mTx = 1, mOvr = 0;
  bit [1:0] mMask = 0;
  bit [7:0] mBuf = 0;

  always #4 clk = ~clk;

  serial_irq_port u_dut (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .serIn(serIn), .serOut(serOut),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .rdData(rdData), .irqReq(irqReq)
  );

  function automatic bit [7:0] expStat();
    return {5'b0, mOvr, mTx, mRx};
  endfunction

  function automatic bit expIrq();
    return (mRx & mMask[0]) | (mTx & mMask[1]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // one clock of stimulus, starting and ending at a falling edge
  task automatic tick(input bit sh, input bit sb, input bit we,
                      input bit [1:0] wa, input bit [7:0] wd);
    shiftEn = sh; serIn = sb; wrEn = we; wrAddr = wa; wrData = wd;
    @(posedge clk); #1;
    shiftEn = 0; wrEn = 0;
    @(negedge clk);
  endtask

  task automatic readReg(input bit [1:0] a, output logic [7:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic cpuWrite(input bit [1:0] a, input bit [7:0] d);
    tick(0, 0, 1, a, d);
    if (a == 2'd1) begin
      if (d[0]) mRx = 0;
      if (d[1]) mTx = 0;
      if (d[2]) mOvr = 0;
    end else if (a == 2'd2) mMask = d[1:0];
  endtask

  task automatic checkRegs(input string req);
    logic [7:0] d;
    readReg(2'd1, d); check({req, " status"}, d, expStat());
    readReg(2'd0, d); check({req, " data"}, d, mBuf);
    check({req, " irq"}, irqReq, expIrq());
  endtask

  // one 8-bit frame in both directions; clrLast clears receive-full on the final pulse
  task automatic frame(input bit load, input bit [7:0] tb, input bit [7:0] rb,
                       input bit clrLast, input bit gaps);
    bit oldRx;
    if (load) begin tick(0, 0, 1, 2'd0, tb); mTx = 0; end
    for (int i = 0; i < 8; i++) begin
      if (gaps) begin
        int g = $urandom_range(0, 2);
        for (int k = 0; k < g; k++) tick(0, $urandom_range(0, 1), 0, 0, 0);
      end
      // R3 serial order, MSB first, idle high when not loaded
      check("R3 serOut bit", serOut, load ? tb[7-i] : 1'b1);
      if (i == 7 && clrLast) tick(1, rb[7-i], 1, 2'd1, 8'h01);
      else                   tick(1, rb[7-i], 0, 0, 0);
    end
    oldRx = mRx;
    if (oldRx) mOvr = 1;
    mRx = 1; mBuf = rb;
    if (load) mTx = 1;
    check("R3 serOut idle after frame", serOut, 1'b1);
  endtask

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    readReg(2'd1, d); check("R1 status", d, 8'h02);
    readReg(2'd2, d); check("R1 mask", d, 8'h00);
    readReg(2'd0, d); check("R1 data", d, 8'h00);
    check("R1 irq", irqReq, 1'b0);
    check("R1 serOut", serOut, 1'b1);

    // R4 / R9 enable transmit source only
    cpuWrite(2'd2, 8'h02);
    readReg(2'd2, d); check("R9 mask readback", d, 8'h02);
    check("R4 irq from tx-empty", irqReq, 1'b1);
    cpuWrite(2'd2, 8'h00);
    check("R4 irq masked", irqReq, 1'b0);

    // R6 writing zeros changes nothing, writing one clears
    cpuWrite(2'd1, 8'h00);
    checkRegs("R6 zero write");
    cpuWrite(2'd1, 8'h02);
    checkRegs("R6 clear tx");

    // R2 R3 R5 simultaneous completion
    cpuWrite(2'd2, 8'h03);
    frame(1, 8'hA5, 8'h3C, 0, 0);
    checkRegs("R2 R5 both set");
    cpuWrite(2'd1, 8'h01);
    checkRegs("R5 irq held after rx clear");
    check("R5 irq still high", irqReq, 1'b1);
    cpuWrite(2'd1, 8'h02);
    check("R5 irq low after both cleared", irqReq, 1'b0);

    // R9 idle cycles and reads move nothing
    for (int k = 0; k < 5; k++) tick(0, 1, 0, 0, 0);
    readReg(2'd0, d); readReg(2'd0, d);
    checkRegs("R9 no side effects");

    // R8 overrun: two characters with no clear in between
    frame(0, 8'h00, 8'h81, 0, 1);
    frame(0, 8'h00, 8'h7E, 0, 1);
    checkRegs("R8 overrun set");
    tick(0, 0, 0, 0, 0);
    checkRegs("R8 overrun sticky");
    cpuWrite(2'd1, 8'h05);
    checkRegs("R8 overrun cleared");

    // R7 clear in the same cycle as completion: set wins
    frame(1, 8'h5A, 8'hC3, 1, 0);
    checkRegs("R7 set wins over clear");

    // random traffic
    for (int f = 0; f < 40; f++) begin
      if ($urandom_range(0, 3) == 0) cpuWrite(2'd2, 8'($urandom_range(0, 3)));
      if ($urandom_range(0, 1) == 0) begin
        cpuWrite(2'd1, 8'($urandom_range(0, 7)));
        checkRegs("R6 random clear");
      end
      frame($urandom_range(0, 1), 8'($urandom), 8'($urandom), 0, 1);
      checkRegs("R2 R4 R8 random frame");
    end

    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule